// File: doc/BRIEF.md
# Microcontroller operand address generator

This block works out where an 8-bit accumulator-style CPU should take each operand from. The decoder supplies a mode code and the instruction's operand byte or bytes. The core supplies its live state: the register-bank select bits, the R0 and R1 contents, the 16-bit data pointer, the accumulator and the program counter. The block returns three things: a target space (immediate, internal RAM, special function register, external data or code), a 16-bit resolved address, and a flag that says whether the matching code fetch is served by external program memory.

A request is taken on a rising clock edge while `req_i` is high. The result appears on the outputs one cycle later and stays there until the next request. A two-state machine controls this. `ST_IDLE` moves to `ST_OUT` on a request (transition T_LOAD). `ST_OUT` stays in `ST_OUT` when a new request arrives (T_RELOAD). `ST_OUT` returns to `ST_IDLE` when no request arrives (T_DROP). `ST_IDLE` stays in `ST_IDLE` when no request arrives (T_WAIT). `valid_o` is high only in `ST_OUT`.

The parameter `ROM_KB` sets the internal program ROM size. The value 4 places the top of internal ROM at 0FFFh. The value 8 places it at 1FFFh.

Top module: `oag_resolver`

## Requirements
- R1: A request sampled at a clock edge sets `valid_o` high after that edge. With no request, `valid_o` drops after the next edge while `space_o`, `addr_o` and `ext_fetch_o` keep their values.
- R2: Mode 0 (8-bit immediate) gives space 0 and address {00h, operand}. Mode 1 (16-bit immediate) gives space 0 and address {high operand, operand}.
- R3: Mode 2 (register) gives space 1 (internal RAM) and address bank×8 + operand[2:0], which always lies within 00h–1Fh.
- R4: Mode 3 (direct) gives the operand byte as the address. The space is 2 (SFR) when operand bit 7 is set, and 1 (internal RAM) otherwise.
- R5: Mode 4 (indirect) gives space 1 and the address in R0, or the address in R1 when operand bit 0 is 1, for the full 00h–FFh range.
- R6: Mode 5 (external, 8-bit pointer) gives space 3 and address {00h, R0 or R1}, with the register chosen by operand bit 0.
- R7: Mode 6 (external, data pointer) gives space 3 and the full 16-bit data pointer as the address.
- R8: Mode 7 (code table) gives space 4 and address accumulator + base, wrapping modulo 65536. The base is the data pointer when operand bit 0 is 0, and the program counter when it is 1.
- R9: `ext_fetch_o` is 1 whenever `int_rom_en_i` was low at the request.
- R10: With internal ROM enabled, `ext_fetch_o` is 1 exactly when the checked address exceeds the ROM top (0FFFh for the default `ROM_KB`=4). The checked address is the resolved address in mode 7 and the program counter in every other mode.
- R11: While reset is asserted, and until the first request, `valid_o`, `space_o`, `addr_o` and `ext_fetch_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Resolve request |
| mode_i | input | 3 | Addressing-mode code (0–7) |
| opnd_i | input | 8 | Operand byte (low byte / register / selector) |
| opnd_hi_i | input | 8 | High immediate byte |
| bank_i | input | 2 | Register-bank select |
| r0_i | input | 8 | Current-bank R0 contents |
| r1_i | input | 8 | Current-bank R1 contents |
| dptr_i | input | 16 | Data pointer |
| acc_i | input | 8 | Accumulator |
| pc_i | input | 16 | Program counter |
| int_rom_en_i | input | 1 | High enables internal program ROM |
| valid_o | output | 1 | Result valid (state ST_OUT) |
| space_o | output | 3 | Target space code |
| addr_o | output | 16 | Resolved address |
| ext_fetch_o | output | 1 | Code fetch goes to external memory |

## Verification
The assertions assume that `mode_i`, `opnd_i` and `int_rom_en_i` are stable across the sampling edge whenever `req_i` is high. They also assume that `req_i` is never unknown after reset. The bench changes every input only on the falling clock edge, which keeps it within these assumptions. It checks each result half a cycle after the edge that captured it, so the one-cycle register delay is counted.

// File: rtl/oag_pkg.sv
package oag_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        M_IMM8  = 3'd0,
        M_IMM16 = 3'd1,
        M_REG   = 3'd2,
        M_DIR   = 3'd3,
        M_IND   = 3'd4,
        M_XIND8 = 3'd5,
        M_XDPTR = 3'd6,
        M_CODE  = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        SP_IMM   = 3'd0,
        SP_IRAM  = 3'd1,
        SP_SFR   = 3'd2,
        SP_XDATA = 3'd3,
        SP_CODE  = 3'd4
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } state_e;
endpackage

// File: rtl/oag_bank_map.sv
module oag_bank_map #(
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  logic [BANK_W-1:0]       bank_i,
    input  logic [REG_W-1:0]        reg_i,
    output logic [BANK_W+REG_W-1:0] addr_o
);
    // bank * 2**REG_W + register number
    assign addr_o = {bank_i, reg_i};
endmodule

// File: rtl/oag_space_mux.sv
module oag_space_mux
    import oag_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  mode_e               mode_i,
    input  logic [DATA_W-1:0]   opnd_i,
    input  logic [DATA_W-1:0]   opnd_hi_i,
    input  logic [BANK_W+2:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   r0_i,
    input  logic [DATA_W-1:0]   r1_i,
    input  logic [ADDR_W-1:0]   dptr_i,
    input  logic [DATA_W-1:0]   acc_i,
    input  logic [ADDR_W-1:0]   pc_i,
    output space_e              space_o,
    output logic [ADDR_W-1:0]   addr_o
);
    localparam int PAD_W = ADDR_W - DATA_W;
    localparam int RPAD  = ADDR_W - (BANK_W + 3);

    logic [DATA_W-1:0] ri_sel;
    logic [ADDR_W-1:0] code_base;

    assign ri_sel    = opnd_i[0] ? r1_i : r0_i;
    assign code_base = opnd_i[0] ? pc_i : dptr_i;

    always_comb begin
        space_o = SP_IMM;
        addr_o  = '0;
        unique case (mode_i)
            M_IMM8: begin
                space_o = SP_IMM;
                addr_o  = {{PAD_W{1'b0}}, opnd_i};
            end
            M_IMM16: begin
                space_o = SP_IMM;
                addr_o  = {opnd_hi_i, opnd_i};
            end
            M_REG: begin
                space_o = SP_IRAM;
                addr_o  = {{RPAD{1'b0}}, reg_addr_i};
            end
            M_DIR: begin
                space_o = opnd_i[DATA_W-1] ? SP_SFR : SP_IRAM;
                addr_o  = {{PAD_W{1'b0}}, opnd_i};
            end
            M_IND: begin
                space_o = SP_IRAM;
                addr_o  = {{PAD_W{1'b0}}, ri_sel};
            end
            M_XIND8: begin
                space_o = SP_XDATA;
                addr_o  = {{PAD_W{1'b0}}, ri_sel};
            end
            M_XDPTR: begin
                space_o = SP_XDATA;
                addr_o  = dptr_i;
            end
            M_CODE: begin
                space_o = SP_CODE;
                addr_o  = {{PAD_W{1'b0}}, acc_i} + code_base;
            end
        endcase
    end
endmodule

// File: rtl/oag_fetch_chk.sv
module oag_fetch_chk
    import oag_pkg::*;
#(
    parameter int ROM_KB = 4
) (
    input  logic              int_rom_en_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic              ext_o
);
    localparam longint ROM_BYTES = longint'(ROM_KB) * 1024;
    localparam longint SPACE     = longint'(1) << ADDR_W;

    generate
        if (ROM_BYTES >= SPACE) begin : g_full_rom
            assign ext_o = !int_rom_en_i;
        end else begin : g_part_rom
            localparam logic [ADDR_W-1:0] ROM_TOP = ADDR_W'(ROM_BYTES - 1);
            assign ext_o = !int_rom_en_i || (chk_addr_i > ROM_TOP);
        end
    endgenerate
endmodule

// File: rtl/oag_resolver.sv
module oag_resolver
    import oag_pkg::*;
#(
    parameter int ROM_KB = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [2:0]        mode_i,
    input  logic [7:0]        opnd_i,
    input  logic [7:0]        opnd_hi_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [7:0]        r0_i,
    input  logic [7:0]        r1_i,
    input  logic [15:0]       dptr_i,
    input  logic [7:0]        acc_i,
    input  logic [15:0]       pc_i,
    input  logic              int_rom_en_i,
    output logic              valid_o,
    output logic [2:0]        space_o,
    output logic [15:0]       addr_o,
    output logic              ext_fetch_o
);
    state_e            state_q, state_d;
    mode_e             mode_w;
    space_e            space_w;
    logic [BANK_W+2:0] reg_addr_w;
    logic [ADDR_W-1:0] addr_w;
    logic [ADDR_W-1:0] chk_addr_w;
    logic              ext_w;

    assign mode_w = mode_e'(mode_i);

    oag_bank_map #(.BANK_W(BANK_W), .REG_W(3)) u_bank (
        .bank_i (bank_i),
        .reg_i  (opnd_i[2:0]),
        .addr_o (reg_addr_w)
    );

    oag_space_mux #(.BANK_W(BANK_W)) u_mux (
        .mode_i     (mode_w),
        .opnd_i     (opnd_i),
        .opnd_hi_i  (opnd_hi_i),
        .reg_addr_i (reg_addr_w),
        .r0_i       (r0_i),
        .r1_i       (r1_i),
        .dptr_i     (dptr_i),
        .acc_i      (acc_i),
        .pc_i       (pc_i),
        .space_o    (space_w),
        .addr_o     (addr_w)
    );

    assign chk_addr_w = (mode_w == M_CODE) ? addr_w : pc_i;

    oag_fetch_chk #(.ROM_KB(ROM_KB)) u_fetch (
        .int_rom_en_i (int_rom_en_i),
        .chk_addr_i   (chk_addr_w),
        .ext_o        (ext_w)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_OUT : ST_IDLE;   // T_LOAD / T_WAIT
            ST_OUT:  state_d = req_i ? ST_OUT : ST_IDLE;   // T_RELOAD / T_DROP
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            space_o     <= '0;
            addr_o      <= '0;
            ext_fetch_o <= 1'b0;
        end else if (req_i) begin
            space_o     <= space_w;
            addr_o      <= addr_w;
            ext_fetch_o <= ext_w;
        end
    end

    assign valid_o = (state_q == ST_OUT);
endmodule

// File: rtl/oag_resolver_chk.sv
module oag_resolver_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_i,
    input logic [2:0]  mode_i,
    input logic [7:0]  opnd_i,
    input logic        int_rom_en_i,
    input logic        valid_o,
    input logic [2:0]  space_o,
    input logic [15:0] addr_o,
    input logic        ext_fetch_o
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> valid_o); // R1
    AST_HOLD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> (!valid_o && $stable(addr_o) && $stable(space_o))); // R1
    AST_REG_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && mode_i == 3'd2) |=> (space_o == 3'd1 && addr_o[15:5] == 11'd0)); // R3
    AST_DIR_SFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && mode_i == 3'd3 && opnd_i[7]) |=> (space_o == 3'd2)); // R4
    AST_IND_IRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && mode_i == 3'd4) |=> (space_o == 3'd1 && addr_o[15:8] == 8'd0)); // R5
    AST_XPTR8_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && mode_i == 3'd5) |=> (space_o == 3'd3 && addr_o[15:8] == 8'd0)); // R6
    AST_ROM_OFF_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !int_rom_en_i) |=> ext_fetch_o); // R9
endmodule

bind oag_resolver oag_resolver_chk u_chk (.*);

// File: tb/sim_oag_resolver.sv
`timescale 1ns/1ps
module sim_oag_resolver;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [7:0]  opnd_i = '0;
    logic [7:0]  opnd_hi_i = '0;
    logic [1:0]  bank_i = '0;
    logic [7:0]  r0_i = '0;
    logic [7:0]  r1_i = '0;
    logic [15:0] dptr_i = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] pc_i = '0;
    logic        int_rom_en_i = 1'b1;
    logic        valid_o;
    logic [2:0]  space_o;
    logic [15:0] addr_o;
    logic        ext_fetch_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    oag_resolver u0 (.*);

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  op;
        logic [7:0]  hi;
        logic [1:0]  bank;
        logic [7:0]  r0;
        logic [7:0]  r1;
        logic [15:0] dptr;
        logic [7:0]  acc;
        logic [15:0] pc;
        logic        rom_en;
        logic [2:0]  e_sp;
        logic [15:0] e_addr;
        logic        e_ext;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R2: 8-bit immediate
        '{3'd0, 8'h4D, 8'h00, 2'd0, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0100, 1'b1, 3'd0, 16'h004D, 1'b0},
        // R2: 16-bit immediate
        '{3'd1, 8'h00, 8'h10, 2'd0, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0100, 1'b1, 3'd0, 16'h1000, 1'b0},
        // R3, R10: bank 2 reg 5, pc at ROM top
        '{3'd2, 8'h05, 8'h00, 2'd2, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0FFF, 1'b1, 3'd1, 16'h0015, 1'b0},
        // R3, R10: bank 3 reg 7, pc just past top
        '{3'd2, 8'h07, 8'h00, 2'd3, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h1000, 1'b1, 3'd1, 16'h001F, 1'b1},
        // R4, R9: SFR 88h, ROM disabled
        '{3'd3, 8'h88, 8'h00, 2'd0, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0000, 1'b0, 3'd2, 16'h0088, 1'b1},
        // R4: 7Fh is RAM
        '{3'd3, 8'h7F, 8'h00, 2'd1, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0000, 1'b1, 3'd1, 16'h007F, 1'b0},
        // R4: 80h is SFR
        '{3'd3, 8'h80, 8'h00, 2'd1, 8'h11, 8'h22, 16'h1234, 8'h05, 16'h0000, 1'b1, 3'd2, 16'h0080, 1'b0},
        // R5: via R0, upper RAM
        '{3'd4, 8'h00, 8'h00, 2'd0, 8'hC3, 8'hFE, 16'h1234, 8'h05, 16'h0000, 1'b1, 3'd1, 16'h00C3, 1'b0},
        // R5: via R1
        '{3'd4, 8'h01, 8'h00, 2'd0, 8'hC3, 8'hFE, 16'h1234, 8'h05, 16'h0000, 1'b1, 3'd1, 16'h00FE, 1'b0},
        // R6: external via R1
        '{3'd5, 8'h01, 8'h00, 2'd0, 8'hC3, 8'hFE, 16'h1234, 8'h05, 16'h0000, 1'b1, 3'd3, 16'h00FE, 1'b0},
        // R7: external via data pointer
        '{3'd6, 8'h00, 8'h00, 2'd0, 8'hC3, 8'hFE, 16'hABCD, 8'h05, 16'h0000, 1'b1, 3'd3, 16'hABCD, 1'b0},
        // R8: acc + dptr wraps
        '{3'd7, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 16'hFFF0, 8'h20, 16'h2000, 1'b1, 3'd4, 16'h0010, 1'b0},
        // R8, R10: acc + pc beyond ROM top
        '{3'd7, 8'h01, 8'h00, 2'd0, 8'h00, 8'h00, 16'h0000, 8'h20, 16'h0FF0, 1'b1, 3'd4, 16'h1010, 1'b1},
        // R8, R10: acc + pc exactly at top
        '{3'd7, 8'h01, 8'h00, 2'd0, 8'h00, 8'h00, 16'h0000, 8'h0F, 16'h0FF0, 1'b1, 3'd4, 16'h0FFF, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_i = v.mode; opnd_i = v.op; opnd_hi_i = v.hi; bank_i = v.bank;
        r0_i = v.r0; r1_i = v.r1; dptr_i = v.dptr; acc_i = v.acc;
        pc_i = v.pc; int_rom_en_i = v.rom_en;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R11: reset state
        check("R11 valid", 32'(valid_o), 32'd0);
        check("R11 addr", 32'(addr_o), 32'd0);
        check("R11 space/ext", {28'd0, space_o, ext_fetch_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R11 idle after reset", {valid_o, addr_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            req_i = 1'b1;
            @(negedge clk_i);
            check($sformatf("vec%0d R1 valid", i), 32'(valid_o), 32'd1);
            check($sformatf("vec%0d space", i), 32'(space_o), 32'(VEC[i].e_sp));
            check($sformatf("vec%0d addr", i), 32'(addr_o), 32'(VEC[i].e_addr));
            check($sformatf("vec%0d R9/R10 ext", i), 32'(ext_fetch_o), 32'(VEC[i].e_ext));
        end

        // R1: no request -> outputs hold, valid drops
        req_i = 1'b0;
        mode_i = 3'd1; opnd_i = 8'h55; opnd_hi_i = 8'h66; int_rom_en_i = 1'b0;
        @(negedge clk_i);
        check("R1 valid drop", 32'(valid_o), 32'd0);
        check("R1 addr hold", 32'(addr_o), 32'h0FFF);
        check("R1 space/ext hold", {space_o, ext_fetch_o}, {3'd4, 1'b0});

        // R3: bank 1, register 0 -> 08h
        mode_i = 3'd2; opnd_i = 8'hF8; bank_i = 2'd1; pc_i = 16'h0000; int_rom_en_i = 1'b1;
        req_i = 1'b1;
        @(negedge clk_i);
        check("R3 bank1 r0 addr", 32'(addr_o), 32'h0008);
        check("R3 upper opnd bits ignored space", 32'(space_o), 32'd1);

        // R6: external via R0 with high byte forced zero
        mode_i = 3'd5; opnd_i = 8'h00; r0_i = 8'hFF; r1_i = 8'h01;
        @(negedge clk_i);
        check("R6 r0 addr", 32'(addr_o), 32'h00FF);

        // R8: acc FF + pc FFFF wraps to 00FE
        mode_i = 3'd7; opnd_i = 8'h01; acc_i = 8'hFF; pc_i = 16'hFFFF;
        @(negedge clk_i);
        check("R8 wrap addr", 32'(addr_o), 32'h00FE);
        check("R10 wrapped code addr internal", 32'(ext_fetch_o), 32'd0);
        req_i = 1'b0;
        @(negedge clk_i);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule